// File: doc/BRIEF.md
# Two-Lane Parallel Second-Order Recursive Filter

This block is an all-pole second-order recursive filter, y[k] = x[k] + a1·y[k-1] + a2·y[k-2], that takes two samples per clock and returns two results per clock. Lane 0 carries the even samples x[2n] and lane 1 the odd samples x[2n+1] of one interleaved stream. The filter is built as two copies of the single-sample arithmetic node, one per lane. A fixed rule fixes the wiring and the register count of every feedback link between the two nodes. An original delay of L samples leaving node i lands on node (i+L) mod 2. It passes through floor((i+L)/2) registers.

Under that rule the one-sample-delayed result of the even node reaches the odd node directly, in the same clock cycle. Every other feedback link crosses exactly one register. The results of both nodes are held in output registers, and these registers are also the filter state. Samples enter whenever the input valid flag is high. The matching outputs appear one clock later. Cycles with the flag low leave the state untouched.

Top module: `iir2_unfold`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `y0` and `y1` are all zero after that edge, whatever the inputs are.
- R2: `out_valid` equals the value of `in_valid` at the previous rising edge.
- R3: For an accepted pair, `y0` = `x0` + T(A1·y1_prev) + T(A2·y0_prev). Here y0_prev and y1_prev are the outputs of the previously accepted pair. T(p) is the product shifted arithmetically right by FRAC_W bits, which floors it, and then cut to DATA_W bits.
- R4: For the same pair, `y1` = `x1` + T(A1·y0_new) + T(A2·y1_prev). Here y0_new is the lane-0 result of the same pair, taken within the same clock cycle.
- R5: A cycle with `in_valid` low leaves `y0` and `y1` unchanged. The next accepted pair continues the recursion as if the idle cycle had not occurred.
- R6: With a unit impulse (x0 = 1.0 in Q format, then zeros), the two lanes together reproduce the serial impulse response of the recurrence, sample by sample.
- R7: Every sum wraps modulo 2^DATA_W (two's complement), with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample pair is present on x0/x1 |
| x0 | input | DATA_W | Even sample x[2n], signed fixed point |
| x1 | input | DATA_W | Odd sample x[2n+1], signed fixed point |
| out_valid | output | 1 | y0/y1 hold the results of the pair accepted at the previous edge |
| y0 | output | DATA_W | Even result y[2n] |
| y1 | output | DATA_W | Odd result y[2n+1] |

## Verification
The filter is driven with an impulse on the even lane and then with an impulse on the odd lane. The even-lane impulse exposes a misrouted cross link between the nodes. The odd-lane impulse exposes a wrong register count on the same-cycle path. A dense grid of inputs with alternating signs checks the floor rounding of negative products, which simple truncation toward zero would get wrong. Bursts with idle gaps check that the state is held. Full-scale inputs force wraparound. A serial model of the recurrence, fed the interleaved stream, predicts every result.

// File: rtl/iir2u_pkg.sv
package iir2u_pkg;

    localparam int UNFOLD = 2;   // parallel nodes
    localparam int ORDER  = 2;   // feedback taps per node

    // node that receives a delay-L link leaving node i
    function automatic int link_dest(input int i, input int l);
        return (i + l) % UNFOLD;
    endfunction

    // registers on a delay-L link leaving node i
    function automatic int link_regs(input int i, input int l);
        return (i + l) / UNFOLD;
    endfunction

    // node that feeds node j through its delay-L tap
    function automatic int link_src(input int j, input int l);
        return (j - l + ORDER * UNFOLD) % UNFOLD;
    endfunction

endpackage

// File: rtl/iir2u_node.sv
module iir2u_node #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 12,
    parameter logic signed [DATA_W-1:0] A1 = '0,
    parameter logic signed [DATA_W-1:0] A2 = '0
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] d1,   // y[k-1]
    input  logic signed [DATA_W-1:0] d2,   // y[k-2]
    output logic signed [DATA_W-1:0] y
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW-1:0] p1, p2, s1, s2;

    always_comb begin
        p1 = PW'(A1) * PW'(d1);
        p2 = PW'(A2) * PW'(d2);
        s1 = p1 >>> FRAC_W;
        s2 = p2 >>> FRAC_W;
        y  = x + s1[DATA_W-1:0] + s2[DATA_W-1:0];
    end
endmodule

// File: rtl/iir2u_state.sv
module iir2u_state #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] d [LANES],
    output logic signed [DATA_W-1:0] q [LANES],
    output logic                     vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            for (int k = 0; k < LANES; k++) q[k] <= '0;
        end else begin
            vld <= en;
            if (en)
                for (int k = 0; k < LANES; k++) q[k] <= d[k];
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> (q[0] == $past(q[0])) && (q[LANES-1] == $past(q[LANES-1]))); // R5
endmodule

// File: rtl/iir2_unfold.sv
module iir2_unfold #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 12,
    parameter logic signed [DATA_W-1:0] A1 = 16'sd2048,
    parameter logic signed [DATA_W-1:0] A2 = -16'sd1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] x0,
    input  logic signed [DATA_W-1:0] x1,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] y0,
    output logic signed [DATA_W-1:0] y1
);
    import iir2u_pkg::*;

    logic signed [DATA_W-1:0] x_in   [UNFOLD];
    logic signed [DATA_W-1:0] y_comb [UNFOLD];
    logic signed [DATA_W-1:0] y_reg  [UNFOLD];
    logic signed [DATA_W-1:0] tap    [UNFOLD][ORDER];

    assign x_in[0] = x0;
    assign x_in[1] = x1;

    for (genvar j = 0; j < UNFOLD; j++) begin : g_node
        for (genvar l = 1; l <= ORDER; l++) begin : g_tap
            localparam int SRC = link_src(j, l);
            localparam int KR  = link_regs(SRC, l);
            if (KR == 0) begin : g_direct
                assign tap[j][l-1] = y_comb[SRC];
            end else begin : g_delayed
                assign tap[j][l-1] = y_reg[SRC];
            end
        end

        iir2u_node #(
            .DATA_W(DATA_W), .FRAC_W(FRAC_W), .A1(A1), .A2(A2)
        ) u_node (
            .x (x_in[j]),
            .d1(tap[j][0]),
            .d2(tap[j][1]),
            .y (y_comb[j])
        );
    end

    iir2u_state #(.DATA_W(DATA_W), .LANES(UNFOLD)) u_state (
        .clk(clk), .rst(rst), .en(in_valid),
        .d(y_comb), .q(y_reg), .vld(out_valid)
    );

    assign y0 = y_reg[0];
    assign y1 = y_reg[1];

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && y0 == '0 && y1 == '0)); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(y0) && $stable(y1)); // R5
endmodule

// File: tb/iir2_unfold_test.sv
module iir2_unfold_test;
    localparam int DW = 16;
    localparam int FW = 12;
    localparam logic signed [DW-1:0] C1 = 16'sd3072;   // 0.75
    localparam logic signed [DW-1:0] C2 = -16'sd1536;  // -0.375

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] x0 = '0, x1 = '0;
    logic out_valid;
    logic signed [DW-1:0] y0, y1;

    int n_run = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic signed [DW-1:0] m1 = '0, m2 = '0;   // serial model y[k-1], y[k-2]
    logic signed [DW-1:0] e0 = '0, e1 = '0;
    logic ev = 1'b0;

    always #10 clk = ~clk;

    iir2_unfold #(.DATA_W(DW), .FRAC_W(FW), .A1(C1), .A2(C2)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x0(x0), .x1(x1),
        .out_valid(out_valid), .y0(y0), .y1(y1)
    );

    function automatic logic signed [DW-1:0] term(input logic signed [DW-1:0] c,
                                                  input logic signed [DW-1:0] s);
        logic signed [2*DW-1:0] p;
        p = (2*DW)'(c) * (2*DW)'(s);
        p = p >>> FW;
        return p[DW-1:0];
    endfunction

    function automatic logic signed [DW-1:0] serial(input logic signed [DW-1:0] x);
        logic signed [DW-1:0] r;
        r  = x + term(C1, m1) + term(C2, m2);
        m2 = m1;
        m1 = r;
        return r;
    endfunction

    task automatic check(input string tag, input logic signed [DW-1:0] act,
                         input logic signed [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic v,
                        input logic signed [DW-1:0] a, input logic signed [DW-1:0] b);
        @(negedge clk);
        check("R2 out_valid", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, ev});
        check({tag, " lane0"}, y0, e0);
        check({tag, " lane1"}, y1, e1);
        in_valid = v; x0 = a; x1 = b;
        ev = v;
        if (v) begin
            e0 = serial(a);
            e1 = serial(b);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: busy inputs during reset must not leak
        in_valid = 1'b1; x0 = 16'sd1000; x1 = -16'sd700;
        repeat (3) @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        step("R1 reset", 1'b0, '0, '0);

        // R6: impulse on even lane
        step("R6 impulse", 1'b1, 16'sd4096, '0);
        for (int i = 0; i < 12; i++) step("R6 impulse", 1'b1, '0, '0);

        // R4: impulse on odd lane, same-cycle link
        for (int i = 0; i < 4; i++) step("R4 settle", 1'b1, '0, '0);
        step("R4 odd impulse", 1'b1, '0, 16'sd4096);
        for (int i = 0; i < 10; i++) step("R4 odd impulse", 1'b1, '0, '0);

        // R3: grid sweep, alternating signs for floor rounding
        for (int a = -8; a < 8; a++)
            for (int b = -8; b < 8; b++)
                step("R3 grid", 1'b1, DW'(a * 977 + 3), DW'(b * 613 - 5));

        // R5: bursts separated by idle cycles with junk inputs
        for (int i = 0; i < 40; i++) begin
            step("R5 burst", 1'b1, DW'($urandom_range(0, 8000)) - 16'sd4000,
                 DW'($urandom_range(0, 8000)) - 16'sd4000);
            if (i % 3 == 0) begin
                step("R5 idle", 1'b0, 16'sd31000, -16'sd31000);
                step("R5 idle", 1'b0, -16'sd123, 16'sd456);
            end
        end

        // R7: full-scale drive forcing wraparound
        for (int i = 0; i < 20; i++)
            step("R7 wrap", 1'b1, (i % 2) ? -16'sd32768 : 16'sd32767, 16'sd32767);

        // random tail
        for (int i = 0; i < 200; i++)
            step("R3 random", 1'b1, DW'($urandom()), DW'($urandom()));
        step("R2 final", 1'b0, '0, '0);
        step("R5 final", 1'b0, '0, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule